// File: doc/BRIEF.md
# Sticky Priority Interrupt Vector Generator

This block gathers the interrupt sources of a CAN controller into one 8-bit interrupt vector and a single request line to the CPU. There is one status-change source and a bank of message centers (15 by default), and each center has a request bit. The block keeps the status register, which holds the receive-success flag, the transmit-success flag and a copy of the controller's error state. It also keeps the pending status-change interrupt and its two enable bits.

Once a vector is shown, it stays latched on that source. A new source, even one of higher priority, does not move it. The vector is arbitrated again only when software removes the shown source. The status-change interrupt is removed by reading the status register. A message-center interrupt is removed by writing 0 to that center's request bit. Priority is fixed. Vector 01h, the status change, is the highest. Centers follow in ascending order.

A small CPU register port gives read access to every register. It lets software write the success flags, the enables and the center request bits.

Top module: `irqv_top`

## Requirements
- R1: After reset, `vector` is 00h, `irqLine` is low, and every flag, enable, pending bit and request bit reads 0.
- R2: `irqLine` is high exactly when `vector` is nonzero. `vector` is nonzero exactly when at least one interrupt source (pending status change or center request bit) is active.
- R3: When `vector` leaves 00h, it shows the highest-priority active source. The status change uses 01h and wins over everything. Center k (1..15) uses vector k+1, and a lower value wins.
- R4: While the shown source stays active, `vector` does not change, whatever other sources become active, at higher or lower priority.
- R5: At the clock edge that removes the shown source, `vector` moves to the highest-priority source still active. If no source is left it moves to 00h, and the request line stays high for every move between nonzero values.
- R6: A read of address 0 (the status register) removes the pending status change. It leaves the receive-success and transmit-success flags unchanged.
- R7: Each `rxDone` pulse sets the receive-success flag (status bit 3) and each `txDone` pulse sets the transmit-success flag (status bit 4). Only a CPU write to address 0 changes these flags, loading them from `cpuWdata[3]` and `cpuWdata[4]`. A hardware set in the same cycle wins.
- R8: A status change becomes pending on a success pulse only when the success enable (address 1, bit 0) is set. It becomes pending on a change of `errStateIn` only when the error enable (address 1, bit 1) is set. With an enable clear, that event raises nothing.
- R9: A pulse on `mcSet[k-1]` sets the request bit of center k. A CPU write to address k+1 loads that bit from `cpuWdata[0]`. A hardware set and a CPU clear in the same cycle leave the bit set.
- R10: `cpuRdata` shows the register selected by `cpuAddr` in the same cycle. Address 0 reads {000, tx, rx, err[2:0]}, address 1 reads {000000, errEn, successEn}, address k+1 reads the request bit of center k in bit 0, and any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errStateIn | input | 3 | Error state reported by the controller (level) |
| rxDone | input | 1 | One-cycle pulse on a successful reception |
| txDone | input | 1 | One-cycle pulse on a successful transmission |
| mcSet | input | NUM_MC | Per-center request set pulses; bit k-1 is center k |
| cpuWr | input | 1 | CPU write strobe |
| cpuRd | input | 1 | CPU read strobe (a read of address 0 has a side effect) |
| cpuAddr | input | 5 | CPU register address |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | CPU read data, combinational from `cpuAddr` |
| vector | output | 8 | Currently shown interrupt vector |
| irqLine | output | 1 | Interrupt request to the CPU |

## Verification
The assertions check several properties on every cycle. The request line must match the presence of any active source, and the shown vector must belong to an active source. The vector must stay put while its source lives, and every fresh pick must be the highest-priority active source. Status reads must never lower a success flag, and a set pulse must always leave its request bit standing. What the assertions cannot see is whether sources appear and vanish at the right moments. That covers the enable gating, flag loading on writes, the register read layout and long mixed event sequences, and these are shown by the bench's directed scenarios and its randomized run against the reference model.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int VEC_W     = 8;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 5;
  localparam int ERR_W     = 3;
  localparam int MC_IDX_W  = 5;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 5'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 5'd1;
  localparam int                MC_BASE     = 1;   // center k sits at address k+1

  localparam int BIT_RX     = 3;
  localparam int BIT_TX     = 4;
  localparam int BIT_SUC_EN = 0;
  localparam int BIT_ERR_EN = 1;
  localparam int BIT_REQ    = 0;

  typedef struct packed {
    logic                statusRead;
    logic                statusWrite;
    logic                ctrlWrite;
    logic                mcWrite;
    logic [MC_IDX_W-1:0] mcNum;      // center number 1..NUM_MC
    logic                wrRx;
    logic                wrTx;
    logic                wrSucEn;
    logic                wrErrEn;
    logic                wrReq;
  } strobe_t;
endpackage

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int NUM_MC = 15
) (
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output strobe_t           strb
);
  localparam logic [ADDR_W-1:0] MC_FIRST = ADDR_W'(MC_BASE + 1);
  localparam logic [ADDR_W-1:0] MC_LAST  = ADDR_W'(MC_BASE + NUM_MC);

  logic isMcAddr;
  logic unusedWdata;

  assign isMcAddr    = (cpuAddr >= MC_FIRST) && (cpuAddr <= MC_LAST);
  assign unusedWdata = ^{cpuWdata[DATA_W-1:BIT_TX+1], cpuWdata[BIT_RX-1:BIT_ERR_EN+1]};

  always_comb begin
    strb             = '0;
    strb.statusRead  = cpuRd && (cpuAddr == ADDR_STATUS);
    strb.statusWrite = cpuWr && (cpuAddr == ADDR_STATUS);
    strb.ctrlWrite   = cpuWr && (cpuAddr == ADDR_CTRL);
    strb.mcWrite     = cpuWr && isMcAddr;
    strb.mcNum       = MC_IDX_W'(cpuAddr - ADDR_W'(MC_BASE));
    strb.wrRx        = cpuWdata[BIT_RX];
    strb.wrTx        = cpuWdata[BIT_TX];
    strb.wrSucEn     = cpuWdata[BIT_SUC_EN];
    strb.wrErrEn     = cpuWdata[BIT_ERR_EN];
    strb.wrReq       = cpuWdata[BIT_REQ];
  end
endmodule

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int NUM_MC  = 15,
  localparam int NUM_SRC = NUM_MC + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [ERR_W-1:0]   errStateIn,
  input  logic               rxDone,
  input  logic               txDone,
  input  logic [NUM_MC-1:0]  mcSet,
  output logic [DATA_W-1:0]  cpuRdata,
  output logic [NUM_SRC-1:0] srcNext,
  output logic               statusPendQ,
  output logic [NUM_MC-1:0]  mcReqQ,
  output logic               rxFlagQ,
  output logic               txFlagQ
);
  logic [ERR_W-1:0]  errQ;
  logic              sucEnQ, errEnQ;
  logic              errChange, statusSet, statusPendD;
  logic              rxFlagD, txFlagD;
  logic [NUM_MC-1:0] mcReqD;

  // status-change source
  assign errChange   = (errStateIn != errQ);
  assign statusSet   = (sucEnQ && (rxDone || txDone)) || (errEnQ && errChange);
  assign statusPendD = statusSet || (statusPendQ && !strb.statusRead);

  // success flags: hardware only ever sets them
  assign rxFlagD = rxDone || (strb.statusWrite ? strb.wrRx : rxFlagQ);
  assign txFlagD = txDone || (strb.statusWrite ? strb.wrTx : txFlagQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errQ        <= '0;
      sucEnQ      <= 1'b0;
      errEnQ      <= 1'b0;
      statusPendQ <= 1'b0;
      rxFlagQ     <= 1'b0;
      txFlagQ     <= 1'b0;
    end else begin
      errQ        <= errStateIn;
      statusPendQ <= statusPendD;
      rxFlagQ     <= rxFlagD;
      txFlagQ     <= txFlagD;
      if (strb.ctrlWrite) begin
        sucEnQ <= strb.wrSucEn;
        errEnQ <= strb.wrErrEn;
      end
    end
  end

  // per-center request bits, set wins over a CPU load
  for (genvar i = 0; i < NUM_MC; i++) begin : g_mc
    logic hit;
    assign hit       = strb.mcWrite && (strb.mcNum == MC_IDX_W'(i + 1));
    assign mcReqD[i] = mcSet[i] || (hit ? strb.wrReq : mcReqQ[i]);

    always_ff @(posedge clk) begin
      if (!rstN) mcReqQ[i] <= 1'b0;
      else       mcReqQ[i] <= mcReqD[i];
    end
  end

  // bit j of srcNext stands for vector j+1
  assign srcNext = {mcReqD, statusPendD};

  always_comb begin
    cpuRdata = '0;
    if (cpuAddr == ADDR_STATUS) begin
      cpuRdata[ERR_W-1:0] = errQ;
      cpuRdata[BIT_RX]    = rxFlagQ;
      cpuRdata[BIT_TX]    = txFlagQ;
    end else if (cpuAddr == ADDR_CTRL) begin
      cpuRdata[BIT_SUC_EN] = sucEnQ;
      cpuRdata[BIT_ERR_EN] = errEnQ;
    end else begin
      for (int i = 0; i < NUM_MC; i++) begin
        if (cpuAddr == ADDR_W'(MC_BASE + 1 + i)) cpuRdata[BIT_REQ] = mcReqQ[i];
      end
    end
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcNext,
  output logic [VEC_W-1:0]   vector,
  output logic               irqLine
);
  logic [VEC_W-1:0] vecQ, pickVec;
  logic             heldAlive;

  // fixed priority: lowest index wins
  always_comb begin
    pickVec = '0;
    for (int j = NUM_SRC - 1; j >= 0; j--) begin
      if (srcNext[j]) pickVec = VEC_W'(j + 1);
    end
  end

  // is the source behind the shown vector still present after this edge
  always_comb begin
    heldAlive = 1'b0;
    for (int j = 0; j < NUM_SRC; j++) begin
      if (vecQ == VEC_W'(j + 1)) heldAlive = srcNext[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          vecQ <= '0;
    else if (!heldAlive) vecQ <= pickVec;
  end

  assign vector  = vecQ;
  assign irqLine = |vecQ;
endmodule

// File: rtl/irqv_top.sv
module irqv_top
  import irqv_pkg::*;
#(
  parameter int NUM_MC = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        errStateIn,
  input  logic              rxDone,
  input  logic              txDone,
  input  logic [NUM_MC-1:0] mcSet,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [4:0]        cpuAddr,
  input  logic [7:0]        cpuWdata,
  output logic [7:0]        cpuRdata,
  output logic [7:0]        vector,
  output logic              irqLine
);
  localparam int NUM_SRC = NUM_MC + 1;

  strobe_t            strb;
  logic [NUM_SRC-1:0] srcNext;
  logic               statusPendQ;
  logic [NUM_MC-1:0]  mcReqQ;
  logic               rxFlagQ, txFlagQ;

  irqv_ctrl #(.NUM_MC(NUM_MC)) u_ctrl (
    .cpuWr    (cpuWr),
    .cpuRd    (cpuRd),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .strb     (strb)
  );

  irqv_datapath #(.NUM_MC(NUM_MC)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cpuAddr     (cpuAddr),
    .errStateIn  (errStateIn),
    .rxDone      (rxDone),
    .txDone      (txDone),
    .mcSet       (mcSet),
    .cpuRdata    (cpuRdata),
    .srcNext     (srcNext),
    .statusPendQ (statusPendQ),
    .mcReqQ      (mcReqQ),
    .rxFlagQ     (rxFlagQ),
    .txFlagQ     (txFlagQ)
  );

  irqv_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk     (clk),
    .rstN    (rstN),
    .srcNext (srcNext),
    .vector  (vector),
    .irqLine (irqLine)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int NUM_MC = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        vector,
  input logic              irqLine,
  input logic              statusPendQ,
  input logic [NUM_MC-1:0] mcReqQ,
  input logic [NUM_MC-1:0] mcSet,
  input logic              cpuRd,
  input logic              cpuWr,
  input logic [4:0]        cpuAddr,
  input logic              rxFlagQ,
  input logic              txFlagQ
);
  localparam int NUM_SRC = NUM_MC + 1;

  logic [NUM_SRC-1:0] srcNow;
  logic [7:0]         prevVec;
  logic               prevValid, prevAlive, curAlive, higherAlive;

  assign srcNow = {mcReqQ, statusPendQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevVec   <= '0;
      prevValid <= 1'b0;
    end else begin
      prevVec   <= vector;
      prevValid <= 1'b1;
    end
  end

  always_comb begin
    prevAlive   = 1'b0;
    curAlive    = 1'b0;
    higherAlive = 1'b0;
    for (int j = 0; j < NUM_SRC; j++) begin
      if (prevVec == 8'(j + 1)) prevAlive = srcNow[j];
      if (vector == 8'(j + 1))  curAlive  = srcNow[j];
      if (srcNow[j] && ((vector == 8'd0) || (8'(j + 1) < vector))) higherAlive = 1'b1;
    end
  end

  // R2
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqLine == (srcNow != '0));

  // R2
  shown_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqLine |-> curAlive);

  // R4
  hold_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && prevVec != 8'd0 && prevAlive) |-> (vector == prevVec));

  // R3 R5
  fresh_pick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && (prevVec == 8'd0 || !prevAlive)) |-> !higherAlive);

  // R6
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !cpuWr && cpuAddr == 5'd0) |=>
      ((rxFlagQ || !$past(rxFlagQ)) && (txFlagQ || !$past(txFlagQ))));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|mcSet) |=> ((mcReqQ & $past(mcSet)) == $past(mcSet)));
endmodule

bind irqv_top irqv_checker #(.NUM_MC(NUM_MC)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .vector      (vector),
  .irqLine     (irqLine),
  .statusPendQ (statusPendQ),
  .mcReqQ      (mcReqQ),
  .mcSet       (mcSet),
  .cpuRd       (cpuRd),
  .cpuWr       (cpuWr),
  .cpuAddr     (cpuAddr),
  .rxFlagQ     (rxFlagQ),
  .txFlagQ     (txFlagQ)
);

// File: tb/test_irqv_top.sv
`timescale 1ns/1ps
module test_irqv_top;
  localparam int NMC = 15;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [2:0]     errStateIn = '0;
  logic           rxDone = 1'b0, txDone = 1'b0;
  logic [NMC-1:0] mcSet = '0;
  logic           cpuWr = 1'b0, cpuRd = 1'b0;
  logic [4:0]     cpuAddr = '0;
  logic [7:0]     cpuWdata = '0;
  logic [7:0]     cpuRdata, vector;
  logic           irqLine;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model state (index 1 = status change, k+1 = center k)
  bit srcM [1:NMC+1];
  bit rxM, txM, sucEnM, errEnM;
  int errM, vecM;

  always #2.5 clk = ~clk;

  irqv_top #(.NUM_MC(NMC)) i_irqv_top (
    .clk(clk), .rstN(rstN), .errStateIn(errStateIn), .rxDone(rxDone), .txDone(txDone),
    .mcSet(mcSet), .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .vector(vector), .irqLine(irqLine)
  );

  function automatic void modelReset();
    for (int v = 1; v <= NMC + 1; v++) srcM[v] = 0;
    rxM = 0; txM = 0; sucEnM = 0; errEnM = 0; errM = 0; vecM = 0;
  endfunction

  function automatic void modelClock();
    bit statusSet;
    statusSet = (sucEnM && (rxDone || txDone)) || (errEnM && (int'(errStateIn) != errM));
    srcM[1] = statusSet || (srcM[1] && !(cpuRd && cpuAddr == 0));
    rxM = rxDone || ((cpuWr && cpuAddr == 0) ? cpuWdata[3] : rxM);
    txM = txDone || ((cpuWr && cpuAddr == 0) ? cpuWdata[4] : txM);
    for (int k = 1; k <= NMC; k++)
      srcM[k+1] = mcSet[k-1] || ((cpuWr && int'(cpuAddr) == k + 1) ? cpuWdata[0] : srcM[k+1]);
    if (cpuWr && cpuAddr == 1) begin
      sucEnM = cpuWdata[0];
      errEnM = cpuWdata[1];
    end
    errM = int'(errStateIn);
    if (!(vecM != 0 && srcM[vecM])) begin
      vecM = 0;
      for (int v = NMC + 1; v >= 1; v--) if (srcM[v]) vecM = v;
    end
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one clock: model and design advance together, compare after the edge
  task automatic cyc(string tag);
    @(posedge clk);
    modelClock();
    @(negedge clk);
    checks++;
    if (vector !== 8'(vecM) || irqLine !== (vecM != 0)) begin
      errors++;
      $display("FAIL %s: vector=%0d irq=%0b expected vector=%0d irq=%0b",
               tag, vector, irqLine, vecM, vecM != 0);
    end
    rxDone = 0; txDone = 0; mcSet = '0; cpuWr = 0; cpuRd = 0;
  endtask

  task automatic wr(int addr, int data, string tag);
    cpuWr = 1; cpuAddr = 5'(addr); cpuWdata = 8'(data);
    cyc(tag);
  endtask

  task automatic rdCheck(int addr, int exp, string tag);
    cpuAddr = 5'(addr);
    #1;
    chk(tag, int'(cpuRdata), exp);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 vector", int'(vector), 0);
    chk("R1 irqLine", int'(irqLine), 0);
    rdCheck(0, 0, "R1 status");
    rdCheck(1, 0, "R1 ctrl");
    rdCheck(9, 0, "R1 center");

    wr(1, 3, "R10 ctrl write");
    rdCheck(1, 3, "R10 ctrl read");

    // simultaneous status change and center 1
    mcSet[0] = 1; rxDone = 1; cyc("R3");
    chk("R3 status wins", int'(vector), 1);
    // higher/lower sources arrive while shown
    mcSet[14] = 1; txDone = 1; cyc("R4");
    errStateIn = 3'd5; cyc("R4");
    chk("R4 held", int'(vector), 1);
    rdCheck(0, 8'h1D, "R10 R7 status layout");
    // status read removes vector 1 only
    cpuRd = 1; cpuAddr = 0; cyc("R6");
    chk("R5 next after read", int'(vector), 2);
    rdCheck(0, 8'h1D, "R6 flags kept");
    wr(0, 8'h08, "R7");
    rdCheck(0, 8'h0D, "R7 tx cleared");
    wr(0, 8'h00, "R7");
    rdCheck(0, 8'h05, "R7 rx cleared");
    wr(2, 0, "R5");
    chk("R5 move to center15", int'(vector), 16);
    chk("R5 irq stays", int'(irqLine), 1);
    mcSet[1] = 1; cyc("R4");
    chk("R4 higher ignored", int'(vector), 16);
    wr(16, 0, "R5");
    chk("R5 move to center2", int'(vector), 3);
    wr(3, 0, "R5");
    chk("R5 idle vector", int'(vector), 0);
    chk("R2 irq low", int'(irqLine), 0);

    // enable gating
    wr(1, 0, "R8");
    rxDone = 1; cyc("R8");
    chk("R8 success disabled", int'(vector), 0);
    rdCheck(0, 8'h0D, "R7 rx set while disabled");
    errStateIn = 3'd2; cyc("R8");
    chk("R8 error disabled", int'(vector), 0);
    wr(1, 2, "R8");
    txDone = 1; cyc("R8");
    chk("R8 success still off", int'(vector), 0);
    errStateIn = 3'd6; cyc("R8");
    chk("R8 error enabled", int'(vector), 1);
    cpuRd = 1; cpuAddr = 0; cyc("R6");
    chk("R6 read clears", int'(vector), 0);

    // set wins over clear
    mcSet[4] = 1; cpuWr = 1; cpuAddr = 6; cpuWdata = 0; cyc("R9");
    chk("R9 set wins", int'(vector), 6);
    rdCheck(6, 1, "R9 bit readback");
    wr(6, 0, "R9");
    rdCheck(6, 0, "R9 cleared");

    // two centers together
    mcSet[3] = 1; mcSet[8] = 1; cyc("R3");
    chk("R3 lower center wins", int'(vector), 5);
    wr(5, 0, "R5");
    chk("R5 next center", int'(vector), 10);
    wr(10, 0, "R5");
    chk("R5 back to idle", int'(vector), 0);

    // randomized traffic against the model
    wr(1, 3, "R8");
    void'($urandom(32'd7));
    for (int n = 0; n < 3000; n++) begin
      int op;
      if ($urandom_range(0, 5) == 0) mcSet[$urandom_range(0, NMC-1)] = 1;
      rxDone = ($urandom_range(0, 15) == 0);
      txDone = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 31) == 0) errStateIn = 3'($urandom_range(0, 7));
      op = $urandom_range(0, 9);
      if (op == 0) begin cpuRd = 1; cpuAddr = 0; end
      else if (op == 1) begin cpuWr = 1; cpuAddr = 0; cpuWdata = 8'($urandom_range(0, 255)); end
      else if (op == 2) begin cpuWr = 1; cpuAddr = 1; cpuWdata = 8'($urandom_range(0, 3) | 1); end
      else if (op <= 5) begin cpuWr = 1; cpuAddr = 5'($urandom_range(2, NMC+1)); cpuWdata = 0; end
      else cpuAddr = 5'($urandom_range(0, 31));
      cyc("R2 R3 R4 R5 R7 R9 random");
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule